// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block is the host side of a link to a successive-approximation converter that has a three-wire serial port. The converter takes its sample when chip select goes low and shifts its result out on the serial clock. The block makes both of those signals from the system clock. It collects the returned bits and presents each result on a parallel bus, with a one-cycle valid strobe. The converter has no power pins of its own for mode control: it goes to sleep or wakes according to how many serial clock falling edges it sees before chip select is released. The reader therefore offers three frame types: a conversion, a sleep request that releases chip select early, and a wake frame whose data is thrown away.

Each accepted command latches the frame configuration at that moment. This covers the frame length (16 or 14 serial clocks), the result width (12 or 10 bits), the half period of the serial clock in system clocks, and the quiet time that must pass between frames. After reset the block runs one wake frame on its own. This is because a freshly powered converter may be in either mode.

Top module: `sadc_host_reader`

## Requirements
- R1: While reset is held, cs_n is 1, sclk is 1 and res_valid is 0.
- R2: A conversion frame (cmd_op = 0) holds cs_n low for exactly 16 sclk falling edges, or 14 when cfg_short_frame is 1. sclk idles high. Each high and each low phase lasts cfg_half_div system clocks, with 0 treated as 1, so cs_n stays low for 2 x falls x half system clocks.
- R3: With cfg_res10 = 0, res_data is frame bits 2 to 13, MSB first. Frame bit 0 is the value on sdata just before the first sclk falling edge. Frame bits 0, 1, 14 and 15 have no effect.
- R4: With cfg_res10 = 1, res_data[9:0] is frame bits 2 to 11, MSB first, and res_data[11:10] is 0. Frame bits 0, 1, 12 and 13 have no effect.
- R5: res_valid is a single-cycle pulse. It appears in the first cycle that cs_n is high after a conversion frame, and at no other time.
- R6: A sleep frame (cmd_op = 1) releases cs_n after the 5th sclk falling edge and before the 6th, and produces no res_valid.
- R7: A wake frame (cmd_op = 2) holds cs_n low for 16 falling edges, whatever cfg_short_frame is, and produces no res_valid.
- R8: After cs_n rises, busy stays high and cs_n stays high for G = max(cfg_quiet, 2) cycles. With a command held on cmd_valid, cs_n falls again exactly G + 1 cycles after it rose.
- R9: Commands offered while busy is 1 have no effect, and cmd_op = 3 is never accepted.
- R10: After reset is released, one wake frame runs without any command, with busy high and no res_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_op | input | 2 | 0 convert, 1 sleep, 2 wake, 3 no operation |
| cfg_short_frame | input | 1 | 1 selects the 14-clock conversion frame |
| cfg_res10 | input | 1 | 1 selects a 10-bit result |
| cfg_half_div | input | DIV_W | sclk half period in system clocks (0 acts as 1) |
| cfg_quiet | input | QUIET_W | Quiet time in system clocks after cs_n rises |
| busy | output | 1 | Frame or quiet interval in progress |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter |
| sdata | input | 1 | Serial data from the converter |
| res_data | output | RES_W | Last conversion result |
| res_valid | output | 1 | One-cycle strobe for res_data |

## Verification
A bench model of the converter shifts out a 16-bit word. The model puts non-zero filler in the positions that must be ignored, so that a slip of one bit in either direction changes the decoded result. Conversions are run in both frame lengths and both result widths, with several clock dividers, including a divider of zero. This separates an error in frame length from an error in bit alignment, and both from an error in phase timing. Sleep and wake frames are told apart by the number of falling edges the model counts and by the sleep state the model tracks. Back-to-back commands with the quiet time below and above the minimum show whether the gap comes from the configured value or from the built-in floor.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

   typedef enum logic [1:0] {
      OP_CONVERT = 2'd0,
      OP_SLEEP   = 2'd1,
      OP_WAKE    = 2'd2,
      OP_NONE    = 2'd3
   } sadc_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_QUIET = 2'd2
   } sadc_state_e;

endpackage

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             sclk,
   output logic             fall_evt,
   output logic             rise_evt
);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;
   logic             tick;

   // a divider of zero behaves as one
   assign lim      = (half == '0) ? '0 : half - 1'b1;
   assign tick     = run && (cnt == lim);
   assign fall_evt = tick && sclk;
   assign rise_evt = tick && !sclk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         sclk <= 1'b1;
      end else if (!run) begin
         cnt  <= '0;
         sclk <= 1'b1;
      end else if (tick) begin
         cnt  <= '0;
         sclk <= ~sclk;
      end else begin
         cnt  <= cnt + 1'b1;
      end
   end

   // R11-style parking: once stopped, the clock sits high (supports R2)
   p_sclk_parks_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> sclk)
      else $error("sclk not parked high after stop");

endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
   parameter int FRAME_MAX = 16,
   parameter int RES_W     = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             shift_en,
   input  logic             sdata,
   input  logic             short_frame,
   input  logic             res10,
   input  logic             deliver,
   output logic [RES_W-1:0] res_data,
   output logic             res_valid
);

   localparam int LEAD   = 2;
   localparam int SHORTN = FRAME_MAX - 2;
   localparam int TAIL_W = FRAME_MAX - LEAD - RES_W;
   localparam int NARROW = RES_W - 2;
   localparam int TAIL_N = FRAME_MAX - LEAD - NARROW;

   logic [FRAME_MAX-1:0] shreg;
   logic [FRAME_MAX-1:0] word;
   logic [RES_W-1:0]     nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
      end else if (clear) begin
         shreg <= '0;
      end else if (shift_en) begin
         shreg <= {shreg[FRAME_MAX-2:0], sdata};
      end
   end

   // align a short frame so frame bit 0 always lands in the top position
   assign word = short_frame ? {shreg[SHORTN-1:0], 2'b00} : shreg;

   for (genvar i = 0; i < RES_W; i++) begin : g_bit
      if (i < NARROW) begin : g_both
         assign nxt[i] = res10 ? word[i+TAIL_N] : word[i+TAIL_W];
      end else begin : g_wide
         assign nxt[i] = res10 ? 1'b0 : word[i+TAIL_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_data  <= '0;
         res_valid <= 1'b0;
      end else begin
         res_valid <= deliver;
         if (deliver) begin
            res_data <= nxt;
         end
      end
   end

   p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid)
      else $error("res_valid longer than one cycle");

endmodule

// File: rtl/sadc_frame_ctrl.sv
module sadc_frame_ctrl
   import sadc_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int QUIET_W     = 8,
   parameter int CS_HIGH_MIN = 2,
   parameter int SLEEP_FALLS = 5,
   parameter int FRAME_MAX   = 16,
   parameter bit AUTO_WAKE   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [1:0]         cmd_op,
   input  logic               cfg_short_frame,
   input  logic               cfg_res10,
   input  logic [DIV_W-1:0]   cfg_half_div,
   input  logic [QUIET_W-1:0] cfg_quiet,
   input  logic               fall_evt,
   input  logic               rise_evt,
   output logic               cs_n,
   output logic               run,
   output logic               busy,
   output logic [DIV_W-1:0]   half_q,
   output logic               short_q,
   output logic               res10_q,
   output logic               frame_clear,
   output logic               deliver
);

   localparam int CNT_W = $clog2(FRAME_MAX + 1);
   localparam logic [CNT_W-1:0]   N_LONG  = CNT_W'(FRAME_MAX);
   localparam logic [CNT_W-1:0]   N_SHORT = CNT_W'(FRAME_MAX - 2);
   localparam logic [CNT_W-1:0]   N_SLEEP = CNT_W'(SLEEP_FALLS);
   localparam logic [QUIET_W-1:0] GAP_MIN = QUIET_W'(CS_HIGH_MIN);

   sadc_state_e        state;
   sadc_op_e           op_q;
   sadc_op_e           op_sel;
   logic [CNT_W-1:0]   falls;
   logic [CNT_W-1:0]   target;
   logic [QUIET_W-1:0] qcnt;
   logic [QUIET_W-1:0] gap_q;
   logic               boot_pend;
   logic               req_ok;
   logic               accept;
   logic               done;

   // power-on dummy frame request, present only when enabled
   if (AUTO_WAKE) begin : g_boot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            boot_pend <= 1'b1;
         end else if (accept) begin
            boot_pend <= 1'b0;
         end
      end
   end else begin : g_noboot
      assign boot_pend = 1'b0;
   end

   assign req_ok = cmd_valid && (cmd_op != OP_NONE);
   assign accept = (state == ST_IDLE) && (boot_pend || req_ok);
   assign op_sel = boot_pend ? OP_WAKE : sadc_op_e'(cmd_op);

   always_comb begin
      case (op_q)
         OP_SLEEP: target = N_SLEEP;
         OP_WAKE:  target = N_LONG;
         default:  target = short_q ? N_SHORT : N_LONG;
      endcase
   end

   assign done = (state == ST_FRAME) && rise_evt && (falls == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= OP_NONE;
         falls   <= '0;
         qcnt    <= '0;
         gap_q   <= GAP_MIN;
         cs_n    <= 1'b1;
         short_q <= 1'b0;
         res10_q <= 1'b0;
         half_q  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  state   <= ST_FRAME;
                  op_q    <= op_sel;
                  falls   <= '0;
                  cs_n    <= 1'b0;
                  short_q <= cfg_short_frame;
                  res10_q <= cfg_res10;
                  half_q  <= cfg_half_div;
                  gap_q   <= (cfg_quiet > GAP_MIN) ? cfg_quiet : GAP_MIN;
               end
            end
            ST_FRAME: begin
               if (fall_evt) begin
                  falls <= falls + 1'b1;
               end
               if (done) begin
                  state <= ST_QUIET;
                  cs_n  <= 1'b1;
                  qcnt  <= '0;
               end
            end
            ST_QUIET: begin
               if (qcnt == gap_q - 1'b1) begin
                  state <= ST_IDLE;
               end else begin
                  qcnt <= qcnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign run         = (state == ST_FRAME);
   assign busy        = (state != ST_IDLE) || boot_pend;
   assign frame_clear = accept;
   assign deliver     = done && (op_q == OP_CONVERT);

   p_falls_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FRAME) |-> (falls <= target))
      else $error("more falling edges than the frame allows");

   p_cs_low_in_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy)
      else $error("cs_n low while not busy");

endmodule

// File: rtl/sadc_host_reader.sv
module sadc_host_reader #(
   parameter int DIV_W       = 8,
   parameter int QUIET_W     = 8,
   parameter int CS_HIGH_MIN = 2,
   parameter int SLEEP_FALLS = 5,
   parameter int RES_W       = 12,
   parameter int FRAME_MAX   = 16,
   parameter bit AUTO_WAKE   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [1:0]         cmd_op,
   input  logic               cfg_short_frame,
   input  logic               cfg_res10,
   input  logic [DIV_W-1:0]   cfg_half_div,
   input  logic [QUIET_W-1:0] cfg_quiet,
   output logic               busy,
   output logic               cs_n,
   output logic               sclk,
   input  logic               sdata,
   output logic [RES_W-1:0]   res_data,
   output logic               res_valid
);

   if (FRAME_MAX != RES_W + 4) begin : g_chk_frame
      $error("FRAME_MAX must equal RES_W + 4");
   end
   if (SLEEP_FALLS < 3 || SLEEP_FALLS > 9) begin : g_chk_sleep
      $error("SLEEP_FALLS must lie between 3 and 9");
   end
   if (CS_HIGH_MIN < 1 || CS_HIGH_MIN >= (1 << QUIET_W)) begin : g_chk_gap
      $error("CS_HIGH_MIN must be at least 1 and fit QUIET_W");
   end
   if (DIV_W < 1) begin : g_chk_div
      $error("DIV_W must be positive");
   end

   logic             run;
   logic             fall_evt;
   logic             rise_evt;
   logic [DIV_W-1:0] half_q;
   logic             short_q;
   logic             res10_q;
   logic             frame_clear;
   logic             deliver;

   sadc_frame_ctrl #(
      .DIV_W       (DIV_W),
      .QUIET_W     (QUIET_W),
      .CS_HIGH_MIN (CS_HIGH_MIN),
      .SLEEP_FALLS (SLEEP_FALLS),
      .FRAME_MAX   (FRAME_MAX),
      .AUTO_WAKE   (AUTO_WAKE)
   ) u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .cmd_valid       (cmd_valid),
      .cmd_op          (cmd_op),
      .cfg_short_frame (cfg_short_frame),
      .cfg_res10       (cfg_res10),
      .cfg_half_div    (cfg_half_div),
      .cfg_quiet       (cfg_quiet),
      .fall_evt        (fall_evt),
      .rise_evt        (rise_evt),
      .cs_n            (cs_n),
      .run             (run),
      .busy            (busy),
      .half_q          (half_q),
      .short_q         (short_q),
      .res10_q         (res10_q),
      .frame_clear     (frame_clear),
      .deliver         (deliver)
   );

   sadc_sclk_gen #(
      .DIV_W (DIV_W)
   ) u_sclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .half     (half_q),
      .sclk     (sclk),
      .fall_evt (fall_evt),
      .rise_evt (rise_evt)
   );

   sadc_capture #(
      .FRAME_MAX (FRAME_MAX),
      .RES_W     (RES_W)
   ) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (frame_clear),
      .shift_en    (fall_evt),
      .sdata       (sdata),
      .short_frame (short_q),
      .res10       (res10_q),
      .deliver     (deliver),
      .res_data    (res_data),
      .res_valid   (res_valid)
   );

   p_idle_clock_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> sclk)
      else $error("sclk low while cs_n high");

   p_valid_at_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $rose(cs_n))
      else $error("res_valid away from cs_n release");

   p_gap_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> cs_n)
      else $error("cs_n high for a single cycle");

endmodule

// File: tb/sadc_host_reader_tb.sv
`timescale 1ns/1ps
module sadc_host_reader_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'd3;
   logic        cfg_short_frame = 1'b0;
   logic        cfg_res10 = 1'b0;
   logic [7:0]  cfg_half_div = 8'd1;
   logic [7:0]  cfg_quiet = 8'd3;
   logic        busy;
   logic        cs_n;
   logic        sclk;
   logic        sdata = 1'b0;
   logic [11:0] res_data;
   logic        res_valid;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   sadc_host_reader u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .cmd_valid       (cmd_valid),
      .cmd_op          (cmd_op),
      .cfg_short_frame (cfg_short_frame),
      .cfg_res10       (cfg_res10),
      .cfg_half_div    (cfg_half_div),
      .cfg_quiet       (cfg_quiet),
      .busy            (busy),
      .cs_n            (cs_n),
      .sclk            (sclk),
      .sdata           (sdata),
      .res_data        (res_data),
      .res_valid       (res_valid)
   );

   // converter model
   logic [15:0] dev_word = 16'h0000;
   int          dev_idx = 0;
   int          dev_falls = 0;
   int          last_falls = 0;
   int          frames = 0;
   bit          asleep = 1'b0;

   always @(negedge cs_n) begin
      dev_idx   = 0;
      dev_falls = 0;
      sdata     = asleep ? 1'b1 : dev_word[15];
   end

   always @(negedge sclk) begin
      if (!cs_n) begin
         dev_falls = dev_falls + 1;
         dev_idx   = dev_idx + 1;
         sdata     = (dev_idx < 16) ? (asleep ? dev_idx[0] : dev_word[15-dev_idx]) : 1'b0;
      end
   end

   always @(posedge cs_n) begin
      if (rst_n) begin
         last_falls = dev_falls;
         frames     = frames + 1;
         if (dev_falls >= 3 && dev_falls <= 9) asleep = 1'b1;
         else if (dev_falls >= 10) asleep = 1'b0;
         sdata = 1'b0;
      end
   end

   // port monitor, sampled away from the active edge
   bit          prev_cs = 1'b1;
   int          low_cnt = 0;
   int          high_cnt = 0;
   int          last_low = 0;
   int          last_high = 0;
   int          cs_falls = 0;
   int          vcnt = 0;
   logic [11:0] last_res = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_cs && !cs_n) begin
            last_high = high_cnt;
            low_cnt   = 0;
            cs_falls  = cs_falls + 1;
         end
         if (!prev_cs && cs_n) begin
            last_low = low_cnt;
            high_cnt = 0;
         end
         if (!cs_n) low_cnt = low_cnt + 1;
         else       high_cnt = high_cnt + 1;
         if (res_valid) begin
            vcnt     = vcnt + 1;
            last_res = res_data;
         end
         prev_cs = cs_n;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic issue(input logic [1:0] op);
      wait_idle();
      cmd_op    = op;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_op    = 2'd3;
      wait_idle();
   endtask

   // R1 reset values
   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1 cs_n in reset", cs_n, 1);
      chk("R1 sclk in reset", sclk, 1);
      chk("R1 res_valid in reset", res_valid, 0);
   endtask

   // R10 automatic wake frame after reset
   task automatic t_boot();
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 busy after reset", busy, 1);
      wait_idle();
      chk("R10 boot frame count", frames, 1);
      chk("R10 boot frame falls", last_falls, 16);
      chk("R10 boot no result", vcnt, 0);
   endtask

   // R2 R3 R4 R5 conversion
   task automatic t_convert(input string tag, input logic [15:0] word,
                            input int half, input bit shrt, input bit r10,
                            input int exp_res);
      int v0;
      int n;
      int h;
      dev_word        = word;
      cfg_half_div    = 8'(half);
      cfg_short_frame = shrt;
      cfg_res10       = r10;
      v0 = vcnt;
      n  = shrt ? 14 : 16;
      h  = (half == 0) ? 1 : half;
      issue(2'd0);
      chk({"R2 falls ", tag}, last_falls, n);
      chk({"R2 cs low cycles ", tag}, last_low, 2 * n * h);
      chk({"R5 one strobe ", tag}, vcnt - v0, 1);
      chk({r10 ? "R4 result " : "R3 result ", tag}, int'(last_res), exp_res);
   endtask

   // R6 sleep
   task automatic t_sleep();
      int v0;
      v0 = vcnt;
      issue(2'd1);
      chk("R6 sleep falls", last_falls, 5);
      chk("R6 sleep no result", vcnt - v0, 0);
      chk("R6 device asleep", int'(asleep), 1);
   endtask

   // R7 wake, short frame setting must not shorten it
   task automatic t_wake();
      int v0;
      v0 = vcnt;
      cfg_short_frame = 1'b1;
      issue(2'd2);
      chk("R7 wake falls", last_falls, 16);
      chk("R7 wake no result", vcnt - v0, 0);
      chk("R7 device awake", int'(asleep), 0);
      cfg_short_frame = 1'b0;
   endtask

   // R9 commands ignored while busy, op 3 never taken
   task automatic t_ignore();
      int f0;
      int v0;
      wait_idle();
      f0 = frames;
      v0 = vcnt;
      dev_word = {2'b00, 12'h6C3, 2'b00};
      cmd_op = 2'd0;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (6) @(negedge clk);
      cmd_op = 2'd1;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_idle();
      chk("R9 busy command dropped", frames - f0, 1);
      chk("R9 frame kept full length", last_falls, 16);
      chk("R9 result of first command", int'(last_res), 12'h6C3);
      cmd_op = 2'd3;
      cmd_valid = 1'b1;
      repeat (20) @(negedge clk);
      cmd_valid = 1'b0;
      chk("R9 no-op never starts frame", frames - f0, 1);
      chk("R9 no extra strobe", vcnt - v0, 1);
   endtask

   // R8 gap between frames with command held
   task automatic t_gap(input int q, input int exp_gap);
      int c0;
      wait_idle();
      cfg_quiet = 8'(q);
      cfg_half_div = 8'd1;
      dev_word = 16'h0FF0;
      c0 = cs_falls;
      cmd_op = 2'd0;
      cmd_valid = 1'b1;
      while (cs_falls < c0 + 2) @(negedge clk);
      cmd_valid = 1'b0;
      cmd_op = 2'd3;
      wait_idle();
      chk("R8 cs high between frames", last_high, exp_gap);
   endtask

   initial begin
      t_reset();
      t_boot();
      t_convert("w12 long", {2'b10, 12'hA5C, 2'b11}, 2, 1'b0, 1'b0, 12'hA5C);
      t_convert("w12 short", {2'b01, 12'h3F1, 2'b10}, 3, 1'b1, 1'b0, 12'h3F1);
      t_convert("w10 long div0", {2'b11, 10'h2B7, 4'b1010}, 0, 1'b0, 1'b1, 10'h2B7);
      t_convert("w10 short", {2'b10, 10'h155, 4'b0110}, 1, 1'b1, 1'b1, 10'h155);
      t_convert("w12 ones", {2'b00, 12'hFFF, 2'b00}, 1, 1'b0, 1'b0, 12'hFFF);
      t_sleep();
      t_wake();
      t_convert("after wake", {2'b00, 12'h801, 2'b00}, 2, 1'b0, 1'b0, 12'h801);
      t_ignore();
      t_gap(0, 3);
      t_gap(7, 8);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule